// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block chooses, every clock cycle, which of several hardware threads may send an instruction into a shared pipeline. It holds one program counter per thread. Because of this, moving from one thread to another needs no save or restore of state: the selector only changes which counter it presents. The pipeline, caches and register files sit outside the block. The block sees a per-thread readiness vector, an event that reports a long-latency stall (for example a miss in the outer cache level) together with its thread number, and a per-thread redirect port that loads a new program counter.

The mode input selects one of two policies. The interleaved policy gives the slot to a different ready thread on every cycle, in rotating order, and passes over threads that are not ready. The block-switched policy stays with one thread until that thread reports a long stall. It then moves to the next ready thread and spends one empty cycle while the pipeline refills. Short stalls under this policy simply leave the slot empty.

Top module: `mt_issue_selector`

## Requirements
- R1: After reset, thread i's counter equals PC_BASE + i*PC_STRIDE. The current thread is 0 and the rotation starts its search at thread 0.
- R2: With mode_coarse = 0, the search for the issuing thread starts at the thread after the last one that issued and wraps modulo NUM_THREADS. Each cycle the first ready thread found issues.
- R3: With mode_coarse = 0, a thread whose thread_ready bit is 0 never issues, and the other ready threads keep issuing.
- R4: With mode_coarse = 0 and no ready thread, issue_valid is 0 and the search start holds its value.
- R5: With mode_coarse = 1, the current thread issues on every cycle in which it is ready and no long stall for it arrives. The current thread does not change.
- R6: With mode_coarse = 1, when the current thread is not ready and no long stall is reported, the slot is idle and the current thread is kept.
- R7: With mode_coarse = 1, a long stall for the current thread moves selection to the first ready thread after it in rotating order. The next cycle is an empty bubble. If no other thread is ready, the current thread is kept and no bubble is inserted.
- R8: A long stall that names a thread other than the current one, or that arrives while mode_coarse = 0, has no effect on selection.
- R9: A thread's counter grows by INSN_BYTES in the cycle after that thread issues. Otherwise the counter is unchanged.
- R10: When redirect_valid[i] is 1, thread i's counter takes redirect_pc[i] on the next edge. This takes priority over the increment.
- R11: When issue_valid is 1, issue_pc is the current counter of thread issue_tid, and that thread's ready bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_coarse | input | 1 | 0 = interleave every cycle, 1 = switch only on long stall |
| thread_ready | input | NUM_THREADS | Per-thread ready bit |
| long_stall_valid | input | 1 | Long-latency stall event strobe |
| long_stall_tid | input | TID_W | Thread that took the long stall |
| redirect_valid | input | NUM_THREADS | Per-thread counter load strobe |
| redirect_pc | input | NUM_THREADS x PC_W | Per-thread counter load value |
| issue_valid | output | 1 | A thread issues this cycle |
| issue_tid | output | TID_W | Selected thread |
| issue_pc | output | PC_W | Counter of the selected thread |

## Verification
The hardest case to reach is a long stall for the current thread that lands in the same cycle as other events. One such event is a bubble still pending from an earlier switch. Another is a redirect of the thread being left, or a mode change. The bench reaches these cases in two ways. First, it aims long-stall events at the model's current thread, both when no other thread is ready and when several are. Second, it runs a long phase with randomised readiness, stall targets biased toward the current thread, random redirects and occasional mode flips. The bench compares the block with its reference model on every cycle.

// File: rtl/mt_sel_pkg.sv
package mt_sel_pkg;

    typedef enum logic {
        SEL_FINE   = 1'b0,
        SEL_COARSE = 1'b1
    } sel_mode_e;

    // next index around a ring of n entries
    function automatic int ring_next(input int v, input int n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/mt_rr_picker.sv
module mt_rr_picker #(
    parameter int N  = 4,
    parameter int TW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [TW-1:0] start,
    output logic          found,
    output logic [TW-1:0] tid
);
    always_comb begin
        found = 1'b0;
        tid   = start;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(start) + k) % N;
            if (!found && req[idx]) begin
                found = 1'b1;
                tid   = TW'(idx);
            end
        end
    end
endmodule

// File: rtl/mt_pc_bank.sv
module mt_pc_bank #(
    parameter int              N      = 4,
    parameter int              TW     = 2,
    parameter int              PC_W   = 32,
    parameter logic [PC_W-1:0] BASE   = '0,
    parameter logic [PC_W-1:0] STRIDE = '0,
    parameter logic [PC_W-1:0] STEP   = PC_W'(4)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     adv_valid,
    input  logic [TW-1:0]            adv_tid,
    input  logic [N-1:0]             redir_valid,
    input  logic [N-1:0][PC_W-1:0]   redir_pc,
    output logic [N-1:0][PC_W-1:0]   pcs
);
    for (genvar g = 0; g < N; g++) begin : g_pc
        logic bump;
        assign bump = adv_valid && (adv_tid == TW'(g));

        always_ff @(posedge clk) begin
            if (rst)
                pcs[g] <= BASE + PC_W'(g) * STRIDE;
            else if (redir_valid[g])
                pcs[g] <= redir_pc[g];
            else if (bump)
                pcs[g] <= pcs[g] + STEP;
        end

        // R10
        redir_load_chk: assert property (@(posedge clk) disable iff (rst)
            redir_valid[g] |=> pcs[g] == $past(redir_pc[g]));
        // R9
        pc_step_chk: assert property (@(posedge clk) disable iff (rst)
            (bump && !redir_valid[g]) |=> pcs[g] == $past(pcs[g]) + STEP);
        // R9
        pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!bump && !redir_valid[g]) |=> $stable(pcs[g]));
    end
endmodule

// File: rtl/mt_sched_ctrl.sv
module mt_sched_ctrl
    import mt_sel_pkg::*;
#(
    parameter int N  = 4,
    parameter int TW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_coarse,
    input  logic [N-1:0]  ready,
    input  logic          ls_valid,
    input  logic [TW-1:0] ls_tid,
    output logic          issue_valid,
    output logic [TW-1:0] issue_tid
);
    sel_mode_e     mode;
    logic [TW-1:0] ptr_q, cur_q;
    logic          bubble_q;
    logic          fine_found, alt_found;
    logic [TW-1:0] fine_tid, alt_tid, cur_next;
    logic [N-1:0]  alt_req;
    logic          ls_hit, do_switch;

    assign mode     = sel_mode_e'(mode_coarse);
    assign cur_next = TW'(ring_next(int'(cur_q), N));
    assign alt_req  = ready & ~(N'(1) << cur_q);

    mt_rr_picker #(.N(N), .TW(TW)) u_fine_pick (
        .req(ready), .start(ptr_q), .found(fine_found), .tid(fine_tid));

    mt_rr_picker #(.N(N), .TW(TW)) u_alt_pick (
        .req(alt_req), .start(cur_next), .found(alt_found), .tid(alt_tid));

    always_comb begin
        if (mode == SEL_FINE) begin
            issue_valid = fine_found;
            issue_tid   = fine_tid;
        end else begin
            issue_valid = !bubble_q && ready[cur_q];
            issue_tid   = cur_q;
        end
    end

    assign ls_hit    = (mode == SEL_COARSE) && ls_valid && (ls_tid == cur_q);
    assign do_switch = ls_hit && alt_found;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            cur_q    <= '0;
            bubble_q <= 1'b0;
        end else begin
            bubble_q <= do_switch;
            if (do_switch)
                cur_q <= alt_tid;
            else if (issue_valid)
                cur_q <= issue_tid;
            if (issue_valid)
                ptr_q <= TW'(ring_next(int'(issue_tid), N));
        end
    end

    // R7
    switch_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        do_switch |=> (!mode_coarse || !issue_valid));
    // R5
    coarse_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == SEL_COARSE && !ls_hit) |=> $stable(cur_q));
    // R4
    idle_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == SEL_FINE && ready == '0) |=> $stable(ptr_q));
    // R3
    fine_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == SEL_FINE && ready != '0) |-> issue_valid);
endmodule

// File: rtl/mt_issue_selector.sv
module mt_issue_selector #(
    parameter int              NUM_THREADS = 4,
    parameter int              PC_W        = 32,
    parameter logic [PC_W-1:0] PC_BASE     = PC_W'(32'h0000_1000),
    parameter logic [PC_W-1:0] PC_STRIDE   = PC_W'(32'h0000_0100),
    parameter logic [PC_W-1:0] INSN_BYTES  = PC_W'(4),
    parameter int              TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             mode_coarse,
    input  logic [NUM_THREADS-1:0]           thread_ready,
    input  logic                             long_stall_valid,
    input  logic [TID_W-1:0]                 long_stall_tid,
    input  logic [NUM_THREADS-1:0]           redirect_valid,
    input  logic [NUM_THREADS-1:0][PC_W-1:0] redirect_pc,
    output logic                             issue_valid,
    output logic [TID_W-1:0]                 issue_tid,
    output logic [PC_W-1:0]                  issue_pc
);
    logic [NUM_THREADS-1:0][PC_W-1:0] pcs;

    mt_sched_ctrl #(.N(NUM_THREADS), .TW(TID_W)) u_ctrl (
        .clk(clk), .rst(rst), .mode_coarse(mode_coarse), .ready(thread_ready),
        .ls_valid(long_stall_valid), .ls_tid(long_stall_tid),
        .issue_valid(issue_valid), .issue_tid(issue_tid));

    mt_pc_bank #(.N(NUM_THREADS), .TW(TID_W), .PC_W(PC_W), .BASE(PC_BASE),
                 .STRIDE(PC_STRIDE), .STEP(INSN_BYTES)) u_pcs (
        .clk(clk), .rst(rst), .adv_valid(issue_valid), .adv_tid(issue_tid),
        .redir_valid(redirect_valid), .redir_pc(redirect_pc), .pcs(pcs));

    assign issue_pc = pcs[issue_tid];

    // R11
    ready_issue_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> thread_ready[issue_tid]);
endmodule

// File: tb/test_mt_issue_selector.sv
module test_mt_issue_selector;
    localparam int          T      = 4;
    localparam int          TW     = 2;
    localparam logic [31:0] BASE   = 32'h0000_1000;
    localparam logic [31:0] STRIDE = 32'h0000_0100;
    localparam logic [31:0] STEP   = 32'd4;

    logic clk = 1'b0;
    logic rst;
    logic mode_coarse;
    logic [T-1:0] thread_ready;
    logic long_stall_valid;
    logic [TW-1:0] long_stall_tid;
    logic [T-1:0] redirect_valid;
    logic [T-1:0][31:0] redirect_pc;
    logic issue_valid;
    logic [TW-1:0] issue_tid;
    logic [31:0] issue_pc;

    always #5 clk = ~clk;

    mt_issue_selector #(.NUM_THREADS(T), .PC_W(32), .PC_BASE(BASE),
                        .PC_STRIDE(STRIDE), .INSN_BYTES(STEP)) i_mt_issue_selector (
        .clk(clk), .rst(rst), .mode_coarse(mode_coarse), .thread_ready(thread_ready),
        .long_stall_valid(long_stall_valid), .long_stall_tid(long_stall_tid),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc));

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference state
    int          m_ptr, m_cur;
    bit          m_bub;
    logic [31:0] m_pc [T];

    task automatic model_reset();
        m_ptr = 0; m_cur = 0; m_bub = 0;
        for (int i = 0; i < T; i++) m_pc[i] = BASE + 32'(i) * STRIDE;
    endtask

    task automatic cyc(input string tag, input logic [T-1:0] rdy, input bit coarse,
                       input bit lsv, input int lst, input logic [T-1:0] rv,
                       input logic [31:0] rpc);
        bit e_v; int e_t; int nx;
        @(negedge clk);
        thread_ready = rdy; mode_coarse = coarse;
        long_stall_valid = lsv; long_stall_tid = TW'(lst);
        redirect_valid = rv;
        for (int i = 0; i < T; i++) redirect_pc[i] = rpc + 32'(i) * 32'h10;
        #1;
        e_v = 0; e_t = m_cur;
        if (!coarse) begin
            for (int k = 0; k < T; k++)
                if (!e_v && rdy[(m_ptr + k) % T]) begin e_v = 1; e_t = (m_ptr + k) % T; end
        end else begin
            e_v = !m_bub && rdy[m_cur];
        end
        checks++;
        if (issue_valid !== e_v) begin
            errors++;
            $display("FAIL %s issue_valid actual %0b expected %0b", tag, issue_valid, e_v);
        end
        if (e_v) begin
            checks++;
            if (int'(issue_tid) != e_t || issue_pc !== m_pc[e_t]) begin
                errors++;
                $display("FAIL %s tid/pc actual %0d/%h expected %0d/%h",
                         tag, issue_tid, issue_pc, e_t, m_pc[e_t]);
            end
        end
        // advance model
        if (e_v) begin
            m_pc[e_t] = m_pc[e_t] + STEP;
            m_ptr = (e_t + 1) % T;
            m_cur = e_t;
        end
        for (int i = 0; i < T; i++) if (rv[i]) m_pc[i] = rpc + 32'(i) * 32'h10;
        nx = -1;
        if (coarse && lsv && lst == m_cur)
            for (int k = 1; k < T; k++)
                if (nx < 0 && rdy[(m_cur + k) % T]) nx = (m_cur + k) % T;
        m_bub = (nx >= 0);
        if (nx >= 0) m_cur = nx;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1; mode_coarse = 0; thread_ready = '0; long_stall_valid = 0;
        long_stall_tid = '0; redirect_valid = '0; redirect_pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        model_reset();

        // R1: first issue is thread 0 at base, then each thread's start PC
        cyc("R1", 4'b1111, 0, 0, 0, 0, 0);
        for (int i = 1; i < T; i++) cyc("R1", 4'(1 << i), 0, 0, 0, 0, 0);
        // R2: rotation with all ready
        for (int i = 0; i < 8; i++) cyc("R2", 4'b1111, 0, 0, 0, 0, 0);
        // R3: skip not-ready threads
        for (int i = 0; i < 6; i++) cyc("R3", 4'b1010, 0, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) cyc("R3", 4'b0110, 0, 0, 0, 0, 0);
        // R4: nobody ready, pointer holds
        for (int i = 0; i < 3; i++) cyc("R4", 4'b0000, 0, 0, 0, 0, 0);
        cyc("R4", 4'b1111, 0, 0, 0, 0, 0);
        // R8: long stall ignored in interleaved mode
        for (int i = 0; i < 4; i++) cyc("R8", 4'b1111, 0, 1, m_ptr, 0, 0);
        // R5: block-switched, current thread keeps issuing
        for (int i = 0; i < 6; i++) cyc("R5", 4'b1111, 1, 0, 0, 0, 0);
        // R6: short stall leaves slot idle, no switch
        for (int i = 0; i < 3; i++) cyc("R6", 4'b1111 & ~4'(1 << m_cur), 1, 0, 0, 0, 0);
        cyc("R6", 4'b1111, 1, 0, 0, 0, 0);
        // R8: long stall for a non-current thread
        cyc("R8", 4'b1111, 1, 1, (m_cur + 1) % T, 0, 0);
        cyc("R8", 4'b1111, 1, 0, 0, 0, 0);
        // R7: long stall on current thread, switch with bubble
        cyc("R7", 4'b1111 & ~4'(1 << m_cur), 1, 1, m_cur, 0, 0);
        for (int i = 0; i < 3; i++) cyc("R7", 4'b1111, 1, 0, 0, 0, 0);
        // R7: long stall with nobody else ready, no switch
        cyc("R7", 4'(1 << m_cur), 1, 1, m_cur, 0, 0);
        cyc("R7", 4'(1 << m_cur), 1, 0, 0, 0, 0);
        // R10: redirect, including the thread about to issue
        cyc("R10", 4'b1111, 0, 0, 0, 4'(1 << m_ptr), 32'h0000_8000);
        for (int i = 0; i < 4; i++) cyc("R10", 4'b1111, 0, 0, 0, 0, 0);
        cyc("R10", 4'b1111, 1, 0, 0, 4'b1111, 32'h0002_0000);
        for (int i = 0; i < 3; i++) cyc("R9", 4'b1111, 1, 0, 0, 0, 0);
        // R11: randomised mix
        for (int i = 0; i < 3000; i++) begin
            logic [T-1:0] r;
            bit c, l;
            int t;
            r = 4'($urandom);
            c = ($urandom % 8) != 0 ? ((i / 200) % 2 == 1) : 1'($urandom);
            l = ($urandom % 4) == 0;
            t = ($urandom % 3 == 0) ? int'($urandom % T) : m_cur;
            cyc("R11", r, c, l, t, ($urandom % 10 == 0) ? 4'($urandom) : 4'b0000, $urandom);
        end
        finish_run();
    end
endmodule